// File: doc/BRIEF.md
# Gshare Branch Direction Predictor With Selectable History Length

This block predicts whether a conditional branch will be taken. It keeps a table of two-bit saturating counters. Each lookup selects one counter with an index built from the branch address and a register of recent branch outcomes. The address is mixed with that register by bitwise XOR. A 4-bit length selector sets how much of the outcome register joins the mix. One flag bit selects the whole register. Otherwise a three-bit count selects that many low bits. An all-zero selector leaves the address as the only source of the index.

The front end presents a branch address on the lookup port and reads a taken/not-taken answer in the same cycle. When the branch resolves, the back end drives the update port with the resolved address and the real outcome. On the next clock edge the selected counter is trained and the outcome is shifted into the history. The selector can be changed at any time. The change affects later lookups and updates, and it leaves all stored state untouched.

Top module: `gshare_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the history to zero and sets every counter to 1 (weakly not-taken), so every lookup afterwards answers not-taken.
- R2: `pred_taken` is 1 exactly when the selected counter holds 2 or 3.
- R3: An update adds 1 to the selected counter when `upd_taken` is 1 and subtracts 1 when it is 0. The counter stays at 3 when it is already 3 and taken, and stays at 0 when it is already 0 and not-taken.
- R4: The table has 512 entries. The index is address bits [10:2] XORed with the masked history, zero-extended at the top. History bit k lines up with index bit k.
- R5: With selector bit 3 set, all eight history bits enter the index, whatever selector bits [2:0] hold.
- R6: With selector bit 3 clear, selector bits [2:0] give a count N (0 to 7), and only history bits [N-1:0] enter the index.
- R7: With a selector of 4'b0000, the index is the address field alone, whatever the history holds.
- R8: Each update shifts the history left by one and puts the outcome (1 = taken) into bit 0. The counter trained is the one chosen by the history from before that shift and by the selector of that cycle.
- R9: A lookup is combinational from the stored state. An update shows up in lookups only after the clock edge that captures it.
- R10: Changing the selector clears neither the history nor any counter.
- R11: While `upd_valid` is low, the history and the counters keep their values, whatever `upd_pc` and `upd_taken` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hist_sel | input | 4 | History length selector: bit 3 selects full history, bits [2:0] give the count |
| pred_pc | input | 32 | Branch address to predict |
| pred_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 taken |

## Verification
A bench model of the counters and the history runs next to the block through a vector table. The table trains and looks up the same addresses under every selector form: zero, partial counts, full, and full with nonzero low bits. This shows whether the right history bits reach the index and whether the pre-shift history picks the trained counter. Directed sequences check fixed values. One walks one counter up into saturation and back down through zero, which separates a saturating counter from a wrapping one. One sets a history with only bit 0 set, then reads the same address under several selectors, showing that a selector change keeps the state. One holds the update strobe low while the other update inputs toggle, which exposes any update that ignores the strobe.

// File: rtl/gsh_pkg.sv
package gsh_pkg;

    localparam int CTR_W = 2;

    typedef enum logic [CTR_W-1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // Saturating step of one direction counter.
    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur >= CTR_WEAK_T;
    endfunction

endpackage

// File: rtl/gsh_len_decode.sv
// Turns the length selector into a per-bit history mask.
module gsh_len_decode #(
    parameter int HIST_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  hist_sel,
    output logic [HIST_W-1:0] hist_mask
);
    localparam int CNT_W = SEL_W - 1;

    logic             full_use;
    logic [CNT_W-1:0] use_cnt;

    assign full_use = hist_sel[SEL_W-1];
    assign use_cnt  = hist_sel[CNT_W-1:0];

    // Bit i is enabled when the whole register is selected or the count exceeds i.
    for (genvar i = 0; i < HIST_W; i++) begin : g_bit
        assign hist_mask[i] = full_use | (int'(use_cnt) > i);
    end
endmodule

// File: rtl/gsh_history.sv
// Outcome shift register: newest outcome at bit 0.
module gsh_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_q
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (shift_en) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hist_q = st_q.bits;
endmodule

// File: rtl/gsh_index.sv
// Hash of address field and masked history.
module gsh_index #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 9,
    parameter int HIST_W = 8,
    parameter int PC_LSB = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    input  logic [HIST_W-1:0] mask,
    output logic [IDX_W-1:0]  idx
);
    logic [IDX_W-1:0]  pc_field;
    logic [IDX_W-1:0]  hist_field;
    logic [HIST_W-1:0] hist_used;

    assign pc_field   = pc[PC_LSB +: IDX_W];
    assign hist_used  = hist & mask;
    assign hist_field = IDX_W'(hist_used);
    assign idx        = pc_field ^ hist_field;
endmodule

// File: rtl/gsh_ctr_table.sv
// Table of saturating direction counters, one read port and one trained entry.
module gsh_ctr_table
    import gsh_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][CTR_W-1:0] ctr;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                tbl_d.ctr[e] = CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            tbl_d.ctr[wr_idx] = ctr_next(ctr_e'(tbl_q.ctr[wr_idx]), wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        tbl_q <= tbl_d;
    end

    assign rd_ctr = ctr_e'(tbl_q.ctr[rd_idx]);
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import gsh_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int SEL_W  = 4,
    parameter int IDX_W  = 9,
    parameter int PC_LSB = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] hist_sel,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_mask;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    ctr_e              pred_ctr;

    gsh_len_decode #(.HIST_W(HIST_W), .SEL_W(SEL_W)) i_len (
        .hist_sel  (hist_sel),
        .hist_mask (hist_mask)
    );

    gsh_history #(.HIST_W(HIST_W)) i_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist_q   (hist_q)
    );

    gsh_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) i_pidx (
        .pc   (pred_pc),
        .hist (hist_q),
        .mask (hist_mask),
        .idx  (pred_idx)
    );

    // Trained entry uses the history before this update's shift.
    gsh_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) i_uidx (
        .pc   (upd_pc),
        .hist (hist_q),
        .mask (hist_mask),
        .idx  (upd_idx)
    );

    gsh_ctr_table #(.IDX_W(IDX_W)) i_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_idx),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    assign pred_taken = ctr_says_taken(pred_ctr);
endmodule

// File: rtl/gsh_props.sv
module gsh_props #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  hist_sel,
    input logic [PC_W-1:0]   pred_pc,
    input logic              pred_taken,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist,
    input logic [HIST_W-1:0] mask
);
    AST_RESET_CLEARS_HIST: assert property (@(posedge clk)
        rst |=> hist == '0); // R1

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
        hist_sel[SEL_W-1] |-> mask == '1); // R5

    AST_COUNT_MASK: assert property (@(posedge clk) disable iff (rst)
        !hist_sel[SEL_W-1] |-> ($countones(mask) == int'(hist_sel[SEL_W-2:0])) && ((mask & (mask + 1'b1)) == '0)); // R6

    AST_ZERO_SEL_NO_HIST: assert property (@(posedge clk) disable iff (rst)
        hist_sel == '0 |-> mask == '0); // R7

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)}); // R8

    AST_IDLE_HOLDS_HIST: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(hist)); // R11

    AST_IDLE_HOLDS_PRED: assert property (@(posedge clk) disable iff (rst)
        (!rst && !upd_valid) ##1 ($stable(pred_pc) && $stable(hist_sel)) |-> $stable(pred_taken)); // R11
endmodule

bind gshare_predictor gsh_props #(.PC_W(PC_W), .HIST_W(HIST_W), .SEL_W(SEL_W)) i_props (
    .clk        (clk),
    .rst        (rst),
    .hist_sel   (hist_sel),
    .pred_pc    (pred_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .hist       (hist_q),
    .mask       (hist_mask)
);

// File: tb/test_gshare_predictor.sv
`timescale 1ns/1ps
module test_gshare_predictor;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  hist_sel;
    logic [31:0] pred_pc;
    logic        pred_taken;
    logic        upd_valid;
    logic [31:0] upd_pc;
    logic        upd_taken;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gshare_predictor i_gshare_predictor (
        .clk        (clk),
        .rst        (rst),
        .hist_sel   (hist_sel),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    // Reference model built from the requirements.
    int         m_ctr [512];
    logic [7:0] m_hist;

    function automatic logic [8:0] m_index(input logic [3:0] s, input logic [31:0] pc, input logic [7:0] h);
        logic [7:0] msk;
        int n;
        n   = s[3] ? 8 : int'(s[2:0]);
        msk = (n == 8) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
        return pc[10:2] ^ {1'b0, h & msk};
    endfunction

    function automatic logic m_pred(input logic [3:0] s, input logic [31:0] pc);
        return m_ctr[m_index(s, pc, m_hist)] >= 2;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: pred_taken=%0b expected=%0b (sel=%h pc=%h)", req, act, exp, hist_sel, pred_pc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; upd_valid = 1'b0; upd_taken = 1'b0; upd_pc = '0;
        hist_sel = 4'h0; pred_pc = '0;
        @(negedge clk);
        rst = 1'b0;
        for (int e = 0; e < 512; e++) m_ctr[e] = 1;
        m_hist = '0;
    endtask

    // One cycle: drive, compare with model before the edge, then advance model.
    task automatic step(input logic [3:0] s, input logic [31:0] ppc, input logic uv,
                        input logic [31:0] upc, input logic ut, input string req);
        logic [8:0] wi;
        @(negedge clk);
        hist_sel = s; pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        check(pred_taken, m_pred(s, ppc), req);
        @(posedge clk);
        if (uv) begin
            wi = m_index(s, upc, m_hist);
            if (ut && m_ctr[wi] < 3) m_ctr[wi]++;
            if (!ut && m_ctr[wi] > 0) m_ctr[wi]--;
            m_hist = {m_hist[6:0], ut};
        end
    endtask

    // Lookup only, compared with a fixed expected value.
    task automatic probe(input logic [3:0] s, input logic [31:0] ppc, input logic exp, input string req);
        @(negedge clk);
        hist_sel = s; pred_pc = ppc; upd_valid = 1'b0;
        #1;
        check(pred_taken, exp, req);
    endtask

    typedef struct packed {
        logic [3:0]  sel;
        logic [31:0] ppc;
        logic        uv;
        logic [31:0] upc;
        logic        ut;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'h8, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1},
        '{4'h8, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1},
        '{4'h8, 32'h0000_0104, 1'b1, 32'h0000_0104, 1'b0},
        '{4'h8, 32'h0000_0100, 1'b1, 32'h0000_0108, 1'b1},
        '{4'h3, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1},
        '{4'h3, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1},
        '{4'h3, 32'h0000_0104, 1'b1, 32'h0000_0200, 1'b0},
        '{4'hF, 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1},
        '{4'hF, 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1},
        '{4'h9, 32'h0000_0200, 1'b1, 32'h0000_0204, 1'b1},
        '{4'h1, 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b0},
        '{4'h1, 32'h0000_0200, 1'b1, 32'h0000_0200, 1'b1},
        '{4'h7, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1},
        '{4'h7, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1},
        '{4'h5, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b0},
        '{4'h0, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1},
        '{4'h0, 32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1},
        '{4'h8, 32'h0000_0300, 1'b0, 32'h0000_0300, 1'b1},
        '{4'h2, 32'h0000_0300, 1'b0, 32'h0000_0300, 1'b0},
        '{4'h6, 32'h0000_07FC, 1'b1, 32'h0000_07FC, 1'b1},
        '{4'h6, 32'h0000_07FC, 1'b1, 32'h0000_07FC, 1'b1},
        '{4'hC, 32'h0000_07FC, 1'b1, 32'h0000_07FC, 1'b0},
        '{4'h4, 32'hFFFF_F7FC, 1'b1, 32'h0000_07FC, 1'b1},
        '{4'h8, 32'h0000_07FC, 1'b0, 32'h0000_0000, 1'b0}
    };

    initial begin
        rst = 1'b1; hist_sel = '0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
        repeat (2) @(posedge clk);

        // R1: reset state
        do_reset();
        probe(4'h0, 32'h0000_0000, 1'b0, "R1");
        probe(4'hF, 32'h0000_0100, 1'b0, "R1");
        probe(4'h8, 32'h0000_07FC, 1'b0, "R1");

        // Table walk: R4 R5 R6 R7 R8 against the model
        for (int v = 0; v < NV; v++) begin
            step(VECS[v].sel, VECS[v].ppc, VECS[v].uv, VECS[v].upc, VECS[v].ut, "R4 R8 table");
        end

        // R9: same-cycle update is not yet visible; R2: counter 2 predicts taken
        do_reset();
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R9");
        probe(4'h0, 32'h0000_0100, 1'b1, "R2");
        probe(4'h0, 32'h0000_0104, 1'b0, "R4");

        // R3: saturate at 3, then walk down and saturate at 0
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, "R3");
        probe(4'h0, 32'h0000_0100, 1'b1, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, "R3");
        probe(4'h0, 32'h0000_0100, 1'b0, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b0, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R3");
        step(4'h0, 32'h0000_0100, 1'b1, 32'h0000_0100, 1'b1, "R3");
        probe(4'h0, 32'h0000_0100, 1'b1, "R3");

        // R10 R5 R6 R7: history 0x01 trains entry 0x1FF via pc 0x7FC
        do_reset();
        step(4'h0, 32'h0000_07FC, 1'b1, 32'h0000_07FC, 1'b1, "R7");
        probe(4'h8, 32'h0000_07F8, 1'b1, "R5");
        probe(4'h1, 32'h0000_07F8, 1'b1, "R6");
        probe(4'h0, 32'h0000_07F8, 1'b0, "R7");
        probe(4'hE, 32'h0000_07F8, 1'b1, "R10");

        // R11: strobe low, other update inputs toggling
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            upd_valid = 1'b0; upd_pc = 32'h0000_07F8; upd_taken = k[0];
        end
        probe(4'h8, 32'h0000_07F8, 1'b1, "R11");
        probe(4'h0, 32'h0000_07FC, 1'b1, "R11");

        // R8: entry picked by pre-shift history (0x01) -> 0x1FF to 3, history 0x03
        step(4'h8, 32'h0000_07F8, 1'b1, 32'h0000_07F8, 1'b1, "R8");
        probe(4'h8, 32'h0000_07F8, 1'b0, "R8");
        probe(4'h8, 32'h0000_07F0, 1'b1, "R8");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule